// File: doc/BRIEF.md
# Conversion Result Register Pair with Read Interlock

This block keeps the most recent analog conversion result in two byte-wide registers, a high byte and a low byte. Software reads the high byte first and then the low byte. When the result is wider than a byte, reading the high byte locks the pair. No new result can then change either byte until the low byte has been read, so the two bytes always belong to the same conversion. A result that arrives while the pair is locked is dropped, not queued.

The converter supplies a one-cycle completion pulse with the result data. A comparator supplies a pass flag. When automatic compare is enabled and the flag is low, the result is not stored. The resolution mode is an input. A change of mode clears the high byte, releases any lock, and drops a result that completes in the same cycle. Both bytes are registered: a result accepted at a clock edge shows on the outputs right after that edge.

Top module: `adc_result_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `res_hi` and `res_lo` become 8'h00.
- R2: The mode encoding is 2'b00 = 8-bit, 2'b01 = 10-bit, and 2'b10 or 2'b11 = 12-bit. When a result is accepted in 12-bit mode, `res_hi[3:0]` takes `res_data[11:8]` and `res_hi[7:4]` reads 0. In 10-bit mode, `res_hi[1:0]` takes `res_data[9:8]` and the upper bits read 0. In every mode, `res_lo` takes `res_data[7:0]`.
- R3: In 8-bit mode, `res_hi` reads 0 and `rd_hi` never locks the pair. Every accepted completion updates `res_lo`, including one that coincides with `rd_hi`.
- R4: A completion with `cmp_en`=1 and `cmp_pass`=0 leaves both bytes unchanged. With `cmp_en`=0, the value of `cmp_pass` has no effect.
- R5: In 10-bit or 12-bit mode, a `rd_hi` strobe locks the pair. A completion in the same cycle as that strobe, or in any later cycle before the unlocking low read, is discarded.
- R6: A `rd_lo` strobe while the pair is locked releases the lock. A completion in that same cycle is still discarded, and the next completion is stored.
- R7: A `rd_lo` strobe with no lock pending has no effect: the next completion is stored.
- R8: A cycle in which `mode` differs from its value at the previous edge has three effects: `res_hi` becomes 0, any lock is released, and a completion in that cycle is discarded. `res_lo` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle pulse: a conversion has completed |
| res_data | input | 12 | Conversion result, right-aligned |
| cmp_en | input | 1 | Automatic compare enabled |
| cmp_pass | input | 1 | Compare condition met for the current result |
| mode | input | 2 | Resolution: 00 8-bit, 01 10-bit, 1x 12-bit |
| rd_hi | input | 1 | High byte read strobe |
| rd_lo | input | 1 | Low byte read strobe |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |

## Verification
Suppose the lock flag were left set by mistake. Every later result would then be dropped, and the bytes would freeze from the first edge after the missed release. Suppose instead the lock failed to set. A completion one cycle after a high read would change the bytes at the very next edge. The bench therefore places completions in the cycle of a high read, in the cycle of the unlocking low read, and in the cycle of a mode change. It compares both bytes one cycle later.

// File: rtl/adc_res_pkg.sv
// Shared definitions for the result register pair: the resolution mode encoding.
// Assumes the mode is a 2-bit field; both upper codes select 12-bit.
package adc_res_pkg;
    typedef enum logic [1:0] {
        RM_8   = 2'b00,
        RM_10  = 2'b01,
        RM_12  = 2'b10,
        RM_12B = 2'b11
    } res_mode_e;
endpackage

// File: rtl/adc_res_mode_trk.sv
// Tracks the previous mode and flags a cycle where mode differs from it.
// Also reports whether the present mode is wider than a byte.
// Assumes mode is synchronous to clk. Resets to 8-bit.
module adc_res_mode_trk
    import adc_res_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    output logic       mode_chg,
    output logic       wide
);
    logic [1:0] mode_q;

    // Remember the mode seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= RM_8;
        else        mode_q <= mode;
    end

    // Change detection and width decode.
    always_comb begin
        mode_chg = (mode != mode_q);
        wide     = (mode != RM_8);
    end
endmodule

// File: rtl/adc_res_lock.sv
// Read interlock. A high read in a wide mode sets the lock; a low read releases it.
// A mode change clears it. The block output also covers the cycle of the high read itself.
// Assumes the strobes are one-cycle pulses.
module adc_res_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic wide,
    input  logic mode_chg,
    input  logic rd_hi,
    input  logic rd_lo,
    output logic lock_q,
    output logic block
);
    logic lock_d;

    // Next lock state: set by a high read, held until a low read, killed by a mode change.
    always_comb begin
        lock_d = wide && !mode_chg && (rd_hi || (lock_q && !rd_lo));
        block  = lock_q || (rd_hi && wide);
    end

    // Lock register.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end
endmodule

// File: rtl/adc_res_gate.sv
// Decides whether a completing result may be written into the pair.
// Assumes res_valid is a one-cycle pulse.
module adc_res_gate (
    input  logic res_valid,
    input  logic cmp_en,
    input  logic cmp_pass,
    input  logic block,
    input  logic mode_chg,
    output logic upd
);
    // Store only when compare allows it, the pair is unlocked and the mode is steady.
    always_comb begin
        upd = res_valid && (!cmp_en || cmp_pass) && !block && !mode_chg;
    end
endmodule

// File: rtl/adc_res_regs.sv
// The high/low byte registers. Formats the result for the present mode.
// The high byte is cleared on a mode change.
// Assumes the result is right-aligned in res_data.
module adc_res_regs
    import adc_res_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int NARROW_W = 10,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              clr_hi,
    input  logic [1:0]        mode,
    input  logic [RES_W-1:0]  res_data,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo
);
    logic [BYTE_W-1:0] hi_fmt;

    // Build the high byte from the result bits that the mode keeps.
    always_comb begin
        case (mode)
            RM_8:    hi_fmt = '0;
            RM_10:   hi_fmt = BYTE_W'(res_data[NARROW_W-1:BYTE_W]);
            default: hi_fmt = BYTE_W'(res_data[RES_W-1:BYTE_W]);
        endcase
    end

    // High byte: cleared on a mode change, loaded on an accepted result.
    always_ff @(posedge clk) begin
        if (!rst_n)      res_hi <= '0;
        else if (clr_hi) res_hi <= '0;
        else if (upd)    res_hi <= hi_fmt;
    end

    // Low byte: loaded on an accepted result.
    always_ff @(posedge clk) begin
        if (!rst_n)   res_lo <= '0;
        else if (upd) res_lo <= res_data[BYTE_W-1:0];
    end
endmodule

// File: rtl/adc_result_latch.sv
// Top of the conversion result pair. Ties together mode tracking, the read interlock,
// the store gate and the byte registers.
// Assumes all inputs are synchronous to clk.
module adc_result_latch #(
    parameter int RES_W    = 12,
    parameter int NARROW_W = 10,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic              cmp_en,
    input  logic              cmp_pass,
    input  logic [1:0]        mode,
    input  logic              rd_hi,
    input  logic              rd_lo,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo
);
    logic mode_chg;
    logic wide;
    logic lock_q;
    logic block;
    logic upd;

    adc_res_mode_trk u_mode (
        .clk(clk), .rst_n(rst_n), .mode(mode), .mode_chg(mode_chg), .wide(wide)
    );

    adc_res_lock u_lock (
        .clk(clk), .rst_n(rst_n), .wide(wide), .mode_chg(mode_chg),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .lock_q(lock_q), .block(block)
    );

    adc_res_gate u_gate (
        .res_valid(res_valid), .cmp_en(cmp_en), .cmp_pass(cmp_pass),
        .block(block), .mode_chg(mode_chg), .upd(upd)
    );

    adc_res_regs #(.RES_W(RES_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .upd(upd), .clr_hi(mode_chg), .mode(mode),
        .res_data(res_data), .res_hi(res_hi), .res_lo(res_lo)
    );
endmodule

// File: rtl/adc_result_latch_chk.sv
// Property checker for the result pair, bound into the top module.
// Assumes the internal nets mode_chg, lock_q and upd exist in the top.
module adc_result_latch_chk #(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RES_W-1:0]  res_data,
    input logic              res_valid,
    input logic              cmp_en,
    input logic              cmp_pass,
    input logic [1:0]        mode,
    input logic              rd_hi,
    input logic              rd_lo,
    input logic              mode_chg,
    input logic              lock_q,
    input logic              upd,
    input logic [BYTE_W-1:0] res_hi,
    input logic [BYTE_W-1:0] res_lo
);
    // R2
    fmt12_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode[1]) |=> (res_hi == BYTE_W'($past(res_data[RES_W-1:BYTE_W]))
                              && res_lo == $past(res_data[BYTE_W-1:0])));

    // R3
    narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (res_hi == '0 && !lock_q));

    // R4
    cmp_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cmp_en && !cmp_pass) |=> $stable(res_lo));

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_q || (rd_hi && mode != 2'b00)) && !mode_chg) |=> ($stable(res_lo) && $stable(res_hi)));

    // R6
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && rd_lo && !rd_hi) |=> !lock_q);

    // R7
    no_spurious_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && !rd_hi) |=> !lock_q);

    // R8
    mode_chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (res_hi == '0 && !lock_q && $stable(res_lo)));
endmodule

bind adc_result_latch adc_result_latch_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
    .cmp_en(cmp_en), .cmp_pass(cmp_pass), .mode(mode), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .mode_chg(mode_chg), .lock_q(lock_q), .upd(upd), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/adc_result_latch_bench.sv
// Scoreboard bench: the driver computes the expected pair from the requirements and queues it.
// A monitor pops each entry and compares it a quarter period after the edge.
module adc_result_latch_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] hi;
        logic [7:0] lo;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic        cmp_en = 1'b0;
    logic        cmp_pass = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        rd_hi = 1'b0;
    logic        rd_lo = 1'b0;
    logic [7:0]  res_hi;
    logic [7:0]  res_lo;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    // Reference state, kept by the bench from the requirements.
    logic [1:0] m_prev = 2'b00;
    logic       m_lock = 1'b0;
    logic [7:0] e_hi = '0;
    logic [7:0] e_lo = '0;

    adc_result_latch u_adc_result_latch (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .cmp_en(cmp_en), .cmp_pass(cmp_pass), .mode(mode), .rd_hi(rd_hi),
        .rd_lo(rd_lo), .res_hi(res_hi), .res_lo(res_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply one cycle of stimulus and queue the pair expected after the next edge.
    task automatic step(input logic v, input logic [11:0] d, input logic ce, input logic cp,
                        input logic [1:0] m, input logic rh, input logic rl, input string tag);
        logic chg, wide, blk, upd;
        exp_t e;
        @(negedge clk);
        res_valid = v; res_data = d; cmp_en = ce; cmp_pass = cp;
        mode = m; rd_hi = rh; rd_lo = rl;
        chg  = (m != m_prev);
        wide = (m != 2'b00);
        blk  = m_lock || (rh && wide);
        upd  = v && (!ce || cp) && !blk && !chg;
        if (chg) e_hi = 8'h00;
        else if (upd) e_hi = (m == 2'b00) ? 8'h00 : (m == 2'b01) ? {6'b0, d[9:8]} : {4'b0, d[11:8]};
        if (upd) e_lo = d[7:0];
        m_lock = wide && !chg && (rh || (m_lock && !rl));
        m_prev = m;
        e.hi = e_hi; e.lo = e_lo; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare outputs with the queued expectation after each edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (res_hi !== e.hi || res_lo !== e.lo) begin
                fails++;
                $display("FAIL %s: got hi=%h lo=%h expected hi=%h lo=%h",
                         e.tag, res_hi, res_lo, e.hi, e.lo);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 12'h000, 0, 0, 2'b00, 0, 0, "R1 reset");
        step(0, 12'h000, 0, 0, 2'b10, 0, 0, "R8 enter 12-bit");
        step(1, 12'hABC, 0, 0, 2'b10, 0, 0, "R2 12-bit store");
        step(0, 12'h000, 0, 0, 2'b01, 0, 0, "R8 to 10-bit clears hi");
        step(1, 12'hFFF, 0, 0, 2'b01, 0, 0, "R2 10-bit store");
        step(1, 12'h321, 0, 0, 2'b10, 0, 0, "R8 result on mode change dropped");
        step(1, 12'h123, 1, 0, 2'b10, 0, 0, "R4 compare fail holds");
        step(1, 12'h123, 1, 1, 2'b10, 0, 0, "R4 compare pass stores");
        step(1, 12'h9A5, 0, 0, 2'b10, 0, 0, "R4 compare off ignores pass");
        step(1, 12'h456, 0, 0, 2'b10, 1, 0, "R5 result with high read dropped");
        step(1, 12'h789, 0, 0, 2'b10, 0, 0, "R5 result while locked dropped");
        step(1, 12'h555, 0, 0, 2'b10, 0, 1, "R6 result with unlock dropped");
        step(1, 12'h666, 0, 0, 2'b10, 0, 0, "R6 result after unlock stored");
        step(0, 12'h000, 0, 0, 2'b10, 0, 1, "R7 low read alone");
        step(1, 12'h777, 0, 0, 2'b10, 0, 0, "R7 store after lone low read");
        step(0, 12'h000, 0, 0, 2'b10, 1, 0, "R5 lock again");
        step(0, 12'h000, 0, 0, 2'b00, 0, 0, "R8 mode change releases lock");
        step(1, 12'hF12, 0, 0, 2'b00, 0, 0, "R3 8-bit store");
        step(1, 12'h034, 0, 0, 2'b00, 1, 0, "R3 high read no lock");
        step(1, 12'h056, 0, 0, 2'b00, 0, 0, "R3 8-bit next store");
        step(0, 12'h000, 0, 0, 2'b11, 0, 0, "R8 enter 12-bit alt code");
        step(0, 12'h000, 0, 0, 2'b11, 1, 0, "R5 lock in 12-bit");
        step(0, 12'h000, 0, 0, 2'b01, 0, 0, "R8 switch releases lock");
        step(1, 12'hE2D, 0, 0, 2'b01, 0, 0, "R8 store after released lock");
        step(0, 12'h000, 0, 0, 2'b01, 0, 0, "R2 idle hold");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule